// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block watches eight active-low interrupt request lines, finds the highest level being requested, and decides whether that level may interrupt the processor. Software controls the decision through a small current-priority register. The register holds a 3-bit threshold and an override flag. A request interrupts only when its level is strictly above the threshold, unless the override flag is set. When the override flag is set, any pending level gets through, and the highest pending level still wins.

When the processor acknowledges, the block puts the winning level on a 3-bit restart vector and disarms itself. It raises no further interrupt until software writes the current-priority register again. That write may carry the same value as before. Requests are never stored inside the block. A line that loses arbitration is serviced later only if it is still held low when its turn comes.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset, `irq` and `vec` are 0. The block is disarmed, so no request produces an interrupt until the first register write.
- R2: A request line is active when it is at logic 0. Bit i of `req_n` is level i, and level 7 has the highest priority. When several lines are active, an acknowledge of an eligible request loads the highest active level into `vec`.
- R3: Without the override flag, the winning level raises `irq` only when it is strictly greater than the threshold in `cpr_wdata[2:0]`. For example, with a threshold of 5, levels 5 and below are ignored and levels 6 and 7 interrupt.
- R4: With a register value of 0 and only line 0 active, no interrupt is produced.
- R5: A write with `cpr_wdata[3]`=1 sets the override. While it is set, every active level, including level 0, is eligible, and the highest active level is reported.
- R6: Requests are not latched. When the eligible request is released, `irq` falls one cycle later. A request that lost arbitration gets an interrupt later only while its line is still low.
- R7: An acknowledge taken while `irq` conditions hold clears the armed state. No interrupt follows until `cpr_wr` is pulsed again, and rewriting the same value re-arms the block.
- R8: `irq` is registered. It reflects the request lines and register state of the previous cycle. `vec` holds its value until the next acknowledge.
- R9: An acknowledge with no eligible armed request loads 0 into `vec` and leaves the armed state unchanged.
- R10: When a register write and an acknowledge fall in the same cycle, the acknowledge still loads `vec`, and the block ends that cycle armed with the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 8 | Interrupt request lines, active low, bit index = level |
| cpr_wdata | input | 4 | Register write data: [2:0] threshold, [3] override |
| cpr_wr | input | 1 | Register write strobe; loads data and arms the block |
| ack | input | 1 | Processor acknowledge pulse |
| irq | output | 1 | Interrupt request to the processor, active high |
| vec | output | 3 | Restart vector: level captured at the last acknowledge |

## Verification
Every result of this block appears at the first rising edge after the inputs that caused it. Both `irq` and `vec` depend on the request lines and the register state of the cycle before. The bench drives a stimulus on a falling edge and computes the expected `irq`/`vec` pair from the requirements. It then queues that pair, and a monitor pops it and compares it one time unit after the following rising edge. This fixed one-edge lag covers the re-arm write, the acknowledge that disarms, and the release of a request, with no waiting loops. The reset state is checked directly while reset is held.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   // What an acknowledge did in a given cycle
   typedef enum logic [1:0] {
      ACK_IDLE  = 2'd0,   // no acknowledge this cycle
      ACK_SERVE = 2'd1,   // acknowledge met an eligible, armed request
      ACK_EMPTY = 2'd2    // acknowledge with nothing eligible
   } ack_kind_e;

   // Number of bits needed to index a level
   function automatic int unsigned lvl_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N = 8,
   localparam int unsigned W = irq_arb_pkg::lvl_bits(N)
) (
   input  logic [N-1:0] act,
   output logic         any,
   output logic [W-1:0] win
);

   logic [N:0]   hi_act;   // hi_act[i]: some level >= i is active
   logic [N-1:0] grant;

   assign hi_act[N] = 1'b0;

   for (genvar i = N - 1; i >= 0; i--) begin : g_chain
      assign hi_act[i] = hi_act[i+1] | act[i];
      assign grant[i]  = act[i] & ~hi_act[i+1];
   end

   assign any = hi_act[0];

   always_comb begin
      win = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) win = win | W'(i);
      end
   end

endmodule

// File: rtl/irq_cpr_reg.sv
module irq_cpr_reg #(
   parameter int unsigned RW = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [RW-1:0]          wdata,
   input  irq_arb_pkg::ack_kind_e ack_kind,
   output logic [RW-1:0]          cpr_q,
   output logic                   armed_q,
   output logic [RW-1:0]          cpr_nxt,
   output logic                   armed_nxt
);
   import irq_arb_pkg::*;

   always_comb begin
      cpr_nxt = wr ? wdata : cpr_q;
      if (wr)                         armed_nxt = 1'b1;
      else if (ack_kind == ACK_SERVE) armed_nxt = 1'b0;
      else                            armed_nxt = armed_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpr_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         cpr_q   <= cpr_nxt;
         armed_q <= armed_nxt;
      end
   end

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
   parameter int unsigned W  = 3,
   localparam int unsigned RW = W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   any,
   input  logic [W-1:0]           win,
   input  logic [RW-1:0]          cpr_q,
   input  logic [RW-1:0]          cpr_nxt,
   input  logic                   armed_q,
   input  logic                   armed_nxt,
   input  logic                   ack,
   output irq_arb_pkg::ack_kind_e ack_kind,
   output logic                   irq,
   output logic [W-1:0]           vec
);
   import irq_arb_pkg::*;

   function automatic logic passes(input logic a, input logic [W-1:0] lvl,
                                   input logic [RW-1:0] cpr);
      return a & (cpr[RW-1] | (lvl > cpr[W-1:0]));
   endfunction

   logic pass_now, pass_nxt;

   assign pass_now = passes(any, win, cpr_q);
   assign pass_nxt = passes(any, win, cpr_nxt);

   always_comb begin
      if (!ack)                     ack_kind = ACK_IDLE;
      else if (armed_q && pass_now) ack_kind = ACK_SERVE;
      else                          ack_kind = ACK_EMPTY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
         vec <= '0;
      end else begin
         irq <= armed_nxt & pass_nxt;
         if (ack_kind == ACK_SERVE)      vec <= win;
         else if (ack_kind == ACK_EMPTY) vec <= '0;
      end
   end

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
   parameter int unsigned NUM_LEVELS = 8,
   localparam int unsigned LVL_W = irq_arb_pkg::lvl_bits(NUM_LEVELS),
   localparam int unsigned CPR_W = LVL_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] req_n,
   input  logic [CPR_W-1:0]      cpr_wdata,
   input  logic                  cpr_wr,
   input  logic                  ack,
   output logic                  irq,
   output logic [LVL_W-1:0]      vec
);
   import irq_arb_pkg::*;

   if (NUM_LEVELS < 2 || (NUM_LEVELS & (NUM_LEVELS - 1)) != 0) begin : g_bad_cfg
      $error("prio_irq_arbiter: NUM_LEVELS must be a power of two, at least 2");
   end

   logic [NUM_LEVELS-1:0] req_act;
   logic                  any_req;
   logic [LVL_W-1:0]      win_lvl;
   logic [CPR_W-1:0]      cpr_q, cpr_nxt;
   logic                  armed_q, armed_nxt;
   ack_kind_e             ack_kind;

   assign req_act = ~req_n;

   irq_prio_enc #(.N(NUM_LEVELS)) u_enc (
      .act (req_act),
      .any (any_req),
      .win (win_lvl)
   );

   irq_cpr_reg #(.RW(CPR_W)) u_cpr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (cpr_wr),
      .wdata     (cpr_wdata),
      .ack_kind  (ack_kind),
      .cpr_q     (cpr_q),
      .armed_q   (armed_q),
      .cpr_nxt   (cpr_nxt),
      .armed_nxt (armed_nxt)
   );

   irq_gate #(.W(LVL_W)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .any       (any_req),
      .win       (win_lvl),
      .cpr_q     (cpr_q),
      .cpr_nxt   (cpr_nxt),
      .armed_q   (armed_q),
      .armed_nxt (armed_nxt),
      .ack       (ack),
      .ack_kind  (ack_kind),
      .irq       (irq),
      .vec       (vec)
   );

endmodule

// File: rtl/prio_irq_arbiter_chk.sv
module prio_irq_arbiter_chk #(
   parameter int unsigned NUM_LEVELS = 8,
   localparam int unsigned W  = irq_arb_pkg::lvl_bits(NUM_LEVELS),
   localparam int unsigned RW = W + 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_LEVELS-1:0]  req_n,
   input logic                   cpr_wr,
   input logic                   ack,
   input logic                   irq,
   input logic [W-1:0]           vec,
   input logic                   armed_q,
   input logic [RW-1:0]          cpr_q,
   input logic                   any_req,
   input logic [W-1:0]           win_lvl,
   input irq_arb_pkg::ack_kind_e ack_kind
);
   import irq_arb_pkg::*;

   AST_STRICT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpr_wr && !cpr_q[RW-1] && any_req && win_lvl <= cpr_q[W-1:0]) |=> !irq); // R3
   AST_LEVEL0_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpr_wr && cpr_q == '0 && req_n == ~NUM_LEVELS'(1)) |=> !irq); // R4
   AST_OVERRIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpr_wr && !ack && armed_q && cpr_q[RW-1] && any_req) |=> irq); // R5
   AST_SERVE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_kind == ACK_SERVE && !cpr_wr) |=> (!armed_q && vec == $past(win_lvl))); // R7
   AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> armed_q); // R7
   AST_EMPTY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_kind == ACK_EMPTY && !cpr_wr) |=> (vec == '0 && armed_q == $past(armed_q))); // R9
   AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      cpr_wr |=> armed_q); // R10
   AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !any_req |=> !irq); // R6
   AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> $stable(vec)); // R8

endmodule

bind prio_irq_arbiter prio_irq_arbiter_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_n    (req_n),
   .cpr_wr   (cpr_wr),
   .ack      (ack),
   .irq      (irq),
   .vec      (vec),
   .armed_q  (armed_q),
   .cpr_q    (cpr_q),
   .any_req  (any_req),
   .win_lvl  (win_lvl),
   .ack_kind (ack_kind)
);

// File: tb/prio_irq_arbiter_tb_top.sv
module prio_irq_arbiter_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] req_n;
   logic [3:0] cpr_wdata;
   logic       cpr_wr;
   logic       ack;
   logic       irq;
   logic [2:0] vec;

   always #4 clk = ~clk;   // 8 ns period

   prio_irq_arbiter dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_n     (req_n),
      .cpr_wdata (cpr_wdata),
      .cpr_wr    (cpr_wr),
      .ack       (ack),
      .irq       (irq),
      .vec       (vec)
   );

   typedef struct {
      logic       irq;
      logic [2:0] vec;
      string      tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_chk  = 0;
   int   n_fail = 0;

   // requirement-level model state
   logic [3:0] m_cpr   = 4'd0;
   logic       m_armed = 1'b0;
   logic [2:0] m_vec   = 3'd0;

   task automatic check(input string tag, input string what,
                        input logic [3:0] act, input logic [3:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
      end
   endtask

   function automatic void pick(input logic [7:0] rn, output logic any, output logic [2:0] w);
      any = 1'b0;
      w   = 3'd0;
      for (int i = 0; i < 8; i++) begin
         if (!rn[i]) begin
            any = 1'b1;
            w   = 3'(i);
         end
      end
   endfunction

   // driver: apply one cycle of stimulus and queue the expected result
   task automatic step(input logic [7:0] rn, input logic w_en, input logic [3:0] d,
                       input logic a, input string tag);
      logic       any;
      logic [2:0] w;
      logic       valid;
      logic [3:0] nc;
      logic       na;
      exp_t       e;
      @(negedge clk);
      req_n     = rn;
      cpr_wr    = w_en;
      cpr_wdata = d;
      ack       = a;
      pick(rn, any, w);
      valid = m_armed && any && (m_cpr[3] || w > m_cpr[2:0]);
      if (a) m_vec = valid ? w : 3'd0;
      nc = w_en ? d : m_cpr;
      na = w_en ? 1'b1 : ((a && valid) ? 1'b0 : m_armed);
      m_cpr   = nc;
      m_armed = na;
      e.irq = na && any && (nc[3] || w > nc[2:0]);
      e.vec = m_vec;
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   // monitor: results are due one time unit after the next rising edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(e.tag, "irq", {3'd0, irq}, {3'd0, e.irq});
            check(e.tag, "vec", {1'b0, vec}, {1'b0, e.vec});
         end
      end
   end

   initial begin
      #(8 * 50000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      req_n     = 8'hFF;
      cpr_wdata = 4'd0;
      cpr_wr    = 1'b0;
      ack       = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "irq in reset", {3'd0, irq}, 4'd0);
      check("R1", "vec in reset", {1'b0, vec}, 4'd0);
      rst_n = 1'b1;

      // R1: disarmed until first write
      step(8'h00, 1'b0, 4'd0, 1'b0, "R1");
      step(8'h00, 1'b0, 4'd0, 1'b0, "R1");
      // R3: threshold 5
      step(8'hFF, 1'b1, 4'd5, 1'b0, "R3");
      step(8'hDF, 1'b0, 4'd0, 1'b0, "R3");   // level 5 only
      step(8'hEF, 1'b0, 4'd0, 1'b0, "R3");   // level 4 only
      step(8'hBF, 1'b0, 4'd0, 1'b0, "R3");   // level 6
      // R2: levels 7, 6, 2 together
      step(8'h3B, 1'b0, 4'd0, 1'b0, "R2");
      step(8'h3B, 1'b0, 4'd0, 1'b1, "R2");   // ack -> vec 7
      // R7: disarmed until rewrite of the same value
      step(8'h3B, 1'b0, 4'd0, 1'b0, "R7");
      step(8'h3B, 1'b0, 4'd0, 1'b0, "R7");
      step(8'h3B, 1'b1, 4'd5, 1'b0, "R7");
      // R6: release, and a losing request served later
      step(8'hFF, 1'b0, 4'd0, 1'b0, "R6");
      step(8'h77, 1'b1, 4'd2, 1'b0, "R6");   // levels 7 and 3
      step(8'h77, 1'b0, 4'd0, 1'b1, "R6");   // ack -> vec 7
      step(8'hF7, 1'b1, 4'd2, 1'b0, "R6");   // level 3 still held
      step(8'hF7, 1'b0, 4'd0, 1'b1, "R6");   // ack -> vec 3
      // R8: vec holds between acknowledges
      step(8'hFF, 1'b1, 4'd0, 1'b0, "R8");
      step(8'h7F, 1'b0, 4'd0, 1'b0, "R8");
      // R4: threshold 0, only level 0
      step(8'hFE, 1'b0, 4'd0, 1'b0, "R4");
      step(8'hFE, 1'b0, 4'd0, 1'b0, "R4");
      // R5: override
      step(8'hFE, 1'b1, 4'd8, 1'b0, "R5");
      step(8'hFE, 1'b0, 4'd0, 1'b1, "R5");   // ack -> vec 0, disarm
      step(8'hEE, 1'b1, 4'd8, 1'b0, "R5");   // levels 4 and 0
      step(8'hEE, 1'b0, 4'd0, 1'b1, "R5");   // ack -> vec 4
      step(8'hEF, 1'b1, 4'hF, 1'b0, "R5");   // override with threshold 7
      // R9: acknowledge with nothing eligible
      step(8'hFF, 1'b1, 4'd0, 1'b0, "R9");
      step(8'hFF, 1'b0, 4'd0, 1'b1, "R9");
      step(8'hFD, 1'b0, 4'd0, 1'b0, "R9");   // still armed: level 1 fires
      // R10: write and acknowledge together
      step(8'hFD, 1'b1, 4'd0, 1'b1, "R10");
      step(8'hFD, 1'b0, 4'd0, 1'b0, "R10");
      step(8'hFF, 1'b0, 4'd0, 1'b0, "R6");

      repeat (3) @(posedge clk);
      #2;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule